// File: doc/BRIEF.md
# UART Interrupt Source, Mask and Trigger Controller

This block builds the interrupt request of one UART channel. It keeps four sticky source bits: receive, error, transmit and modem. A mask register gates them into a pending view, and the interrupt line is high whenever any pending bit is set. The source bits are set by event strobes from the datapath and by level conditions. The level conditions compare the receive and transmit FIFO occupancies against trigger thresholds. Software clears source bits by writing ones through a small register bus.

Each trigger threshold comes from a 3-bit field of the FIFO setup register. The field is scaled by a factor fixed by the instance's channel number, which is a parameter. The receive field is biased by one before scaling. The block also drives a receive DMA-busy line, which is high when receive DMA mode is selected and the receive FIFO is empty. The FIFOs and the receive timeout counter sit outside the block. They supply only occupancies and strobes.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bits sit at fixed positions: bit 0 receive, bit 1 error, bit 2 transmit, bit 3 modem. Reading word address 3 returns them in read data bits 3:0.
- R2: Reading word address 4 returns source AND NOT mask. Word address 2 holds the 4-bit mask. `irq` is high exactly when that value is non-zero. It follows any source or mask register change with no added cycle.
- R3: A write to address 4 or to address 3 clears every source bit whose write-data bit (3:0) is 1. Bits written 0 are untouched. If a bit is set and cleared in the same cycle, the set wins.
- R4: `ev_error` sets bit 1, `ev_modem` sets bit 3, `ev_tx_done` sets bit 2 and `ev_rx_timeout` sets bit 0, on the clock edge where the strobe is high. Each bit stays set until it is cleared.
- R5: The FIFO setup register (address 1) has FIFO enable at bit 0 and the transmit field at bits 10:8. The transmit threshold is that field times M. While the FIFO is enabled, bit 2 is set on every edge where `tx_count` is at most that threshold.
- R6: The receive field is bits 6:4 of the FIFO setup register, and the receive threshold is (field+1) times M. The timeout enable is bit 7 of the control register (address 0). While the FIFO is enabled, bit 0 is set on every edge where `rx_count` is at least the threshold. It is also set when `rx_count` is non-zero and the timeout enable is 0.
- R7: M is 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R8: While the FIFO is disabled, bit 0 is set on every edge where `rx_data_ready` is 1. The transmit occupancy then has no effect on bit 2.
- R9: `rx_dma_busy` is high exactly when control bits 1:0 equal 2'b10 and `rx_count` is 0.
- R10: After reset, the control, FIFO setup, mask and source registers read 0, and `irq` is low. Registers read back what was written: control bits 7:0, FIFO setup bits 10:0 and mask bits 3:0. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rx_count | input | OCC_W | Receive FIFO occupancy |
| tx_count | input | OCC_W | Transmit FIFO occupancy |
| rx_data_ready | input | 1 | Receive holding data valid (FIFO disabled mode) |
| ev_error | input | 1 | Receive error strobe |
| ev_modem | input | 1 | Modem status change strobe |
| ev_tx_done | input | 1 | Transmit byte handed off strobe |
| ev_rx_timeout | input | 1 | Receive timeout expiry strobe |
| irq | output | 1 | Interrupt request |
| rx_dma_busy | output | 1 | Receive DMA busy |

## Verification
The bench drives a channel-0 instance and a channel-2 instance with the same stimulus, so that one transmit occupancy lands on opposite sides of the two thresholds. A lost scale factor or a missing receive bias then gives a wrong transmit or receive bit on one instance. Set and clear are driven in the same cycle: a design where the clear wins loses an error event. The FIFO-disabled path is driven with a large transmit count: a design that still applies the level compare raises a spurious transmit interrupt. The DMA-busy line is tested in both DMA and non-DMA modes: a design that ignores the mode field drives busy in the wrong mode.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int SRC_N   = 4;
  localparam int CTRL_W  = 8;
  localparam int FSET_W  = 11;
  localparam int FIELD_W = 3;

  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  localparam int ADR_CTRL = 0;
  localparam int ADR_FSET = 1;
  localparam int ADR_MASK = 2;
  localparam int ADR_SRC  = 3;
  localparam int ADR_PEND = 4;

  // threshold scale per channel number
  function automatic int chan_mult(input int ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
  import uart_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SRC_N-1:0]  src_q,
  input  logic [SRC_N-1:0]  pend,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [FSET_W-1:0] fset_q,
  output logic [SRC_N-1:0]  mask_q,
  output logic [SRC_N-1:0]  clr_o,
  output logic [DATA_W-1:0] rdata
);

  logic              hit_ctrl, hit_fset, hit_mask, hit_src, hit_pend;
  logic [CTRL_W-1:0] ctrl_d;
  logic [FSET_W-1:0] fset_d;
  logic [SRC_N-1:0]  mask_d;
  logic              ctrl_en, fset_en, mask_en;

  assign hit_ctrl = (addr == ADDR_W'(ADR_CTRL));
  assign hit_fset = (addr == ADDR_W'(ADR_FSET));
  assign hit_mask = (addr == ADDR_W'(ADR_MASK));
  assign hit_src  = (addr == ADDR_W'(ADR_SRC));
  assign hit_pend = (addr == ADDR_W'(ADR_PEND));

  // next-state and clock enables
  always_comb begin
    ctrl_en = we & hit_ctrl;
    fset_en = we & hit_fset;
    mask_en = we & hit_mask;
    ctrl_d  = wdata[CTRL_W-1:0];
    fset_d  = wdata[FSET_W-1:0];
    mask_d  = wdata[SRC_N-1:0];
    clr_o   = (we & (hit_src | hit_pend)) ? wdata[SRC_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      fset_q <= '0;
      mask_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (fset_en) fset_q <= fset_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_ctrl)      rdata = DATA_W'(ctrl_q);
    else if (hit_fset) rdata = DATA_W'(fset_q);
    else if (hit_mask) rdata = DATA_W'(mask_q);
    else if (hit_src)  rdata = DATA_W'(src_q);
    else if (hit_pend) rdata = DATA_W'(pend);
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata[DATA_W-1:FSET_W];

  // R10: a write to the mask lands on the next edge
  a_r10_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit_mask) |=> (mask_q == $past(wdata[SRC_N-1:0])));

endmodule

// File: rtl/uart_irq_trig.sv
module uart_irq_trig
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int OCC_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fifo_en,
  input  logic               rx_to_en,
  input  logic [FIELD_W-1:0] tx_field,
  input  logic [FIELD_W-1:0] rx_field,
  input  logic [OCC_W-1:0]   rx_count,
  input  logic [OCC_W-1:0]   tx_count,
  input  logic               rx_data_ready,
  output logic               tx_lvl,
  output logic               rx_lvl
);

  localparam int MULT  = chan_mult(CHANNEL);
  localparam int THR_W = FIELD_W + 1 + 6;
  localparam int CMP_W = (OCC_W > THR_W) ? OCC_W : THR_W;

  logic [CMP_W-1:0] tx_thr, rx_thr, tx_cnt, rx_cnt;

  generate
    if (MULT == 0) begin : g_no_scale
      assign tx_thr = '0;
      assign rx_thr = '0;
      logic unused_fields;
      assign unused_fields = ^{tx_field, rx_field};
    end else begin : g_scale
      localparam int SH = $clog2(MULT);
      assign tx_thr = CMP_W'(tx_field) << SH;
      assign rx_thr = (CMP_W'(rx_field) + CMP_W'(1)) << SH;
    end
  endgenerate

  assign tx_cnt = CMP_W'(tx_count);
  assign rx_cnt = CMP_W'(rx_count);

  always_comb begin
    if (fifo_en) begin
      tx_lvl = (tx_cnt <= tx_thr);
      rx_lvl = (rx_cnt >= rx_thr) || ((rx_cnt != '0) && !rx_to_en);
    end else begin
      tx_lvl = 1'b0;
      rx_lvl = rx_data_ready;
    end
  end

  // R5: an empty transmit FIFO is always at or under the threshold
  a_r5_empty_tx_level: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && tx_count == '0) |-> tx_lvl);
  // R8: FIFO off gives no transmit level request
  a_r8_no_tx_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !tx_lvl);
  // R6: an empty receive FIFO never meets a non-zero threshold
  a_r6_empty_rx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_count == '0 && MULT != 0) |-> !rx_lvl);

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  input  logic [SRC_N-1:0] mask_i,
  output logic [SRC_N-1:0] src_q,
  output logic [SRC_N-1:0] pend_o,
  output logic             irq_o
);

  logic [SRC_N-1:0] src_d;
  logic             src_en;

  always_comb begin
    src_en = |{set_i, clr_i};
    src_d  = (src_q & ~clr_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      src_q <= '0;
    else if (src_en) src_q <= src_d;
  end

  assign pend_o = src_q & ~mask_i;
  assign irq_o  = |pend_o;

  // R3: cleared bits with no concurrent set are low after the edge
  a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~set_i) != '0) |=> ((src_q & $past(clr_i & ~set_i)) == '0));
  // R4: a set bit is visible on the next edge
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((src_q & $past(set_i)) == $past(set_i)));
  // R3: a bit neither set nor cleared keeps its value
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_i | clr_i) == '0) |=> $stable(src_q));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int CHANNEL = 0,
  parameter int OCC_W   = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [OCC_W-1:0]  rx_count,
  input  logic [OCC_W-1:0]  tx_count,
  input  logic              rx_data_ready,
  input  logic              ev_error,
  input  logic              ev_modem,
  input  logic              ev_tx_done,
  input  logic              ev_rx_timeout,
  output logic              irq,
  output logic              rx_dma_busy
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [FSET_W-1:0] fset_q;
  logic [SRC_N-1:0]  mask_q, clr, set, src_q, pend;
  logic              tx_lvl, rx_lvl;

  uart_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .src_q(src_q), .pend(pend), .ctrl_q(ctrl_q),
    .fset_q(fset_q), .mask_q(mask_q), .clr_o(clr), .rdata(bus_rdata)
  );

  uart_irq_trig #(.CHANNEL(CHANNEL), .OCC_W(OCC_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .fifo_en(fset_q[0]), .rx_to_en(ctrl_q[7]),
    .tx_field(fset_q[10:8]), .rx_field(fset_q[6:4]),
    .rx_count(rx_count), .tx_count(tx_count),
    .rx_data_ready(rx_data_ready), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl)
  );

  always_comb begin
    set            = '0;
    set[SRC_RX]    = rx_lvl | ev_rx_timeout;
    set[SRC_ERR]   = ev_error;
    set[SRC_TX]    = tx_lvl | ev_tx_done;
    set[SRC_MODEM] = ev_modem;
  end

  uart_irq_src u_src (
    .clk(clk), .rst_n(rst_n), .set_i(set), .clr_i(clr), .mask_i(mask_q),
    .src_q(src_q), .pend_o(pend), .irq_o(irq)
  );

  assign rx_dma_busy = (ctrl_q[1:0] == 2'b10) && (rx_count == '0);

  logic unused_cfg;
  assign unused_cfg = ^{ctrl_q[6:2], fset_q[7], fset_q[3:1]};

  // R2: a fully masked source set never interrupts
  a_r2_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq);
  // R9: busy only with an empty receive FIFO
  a_r9_busy_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_busy |-> (rx_count == '0));
  // R5: a transmit level request shows in the source bit next edge
  a_r5_tx_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_lvl |=> src_q[SRC_TX]);
  // R4: error strobe reaches the error source bit
  a_r4_error_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_error |=> src_q[SRC_ERR]);

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_we, rx_data_ready;
  logic        ev_error, ev_modem, ev_tx_done, ev_rx_timeout;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, rdata0, rdata2;
  logic [7:0]  rx_count, tx_count;
  logic        irq0, irq2, busy0, busy2;

  uart_irq_ctrl #(.CHANNEL(0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .rx_count(rx_count),
    .tx_count(tx_count), .rx_data_ready(rx_data_ready), .ev_error(ev_error),
    .ev_modem(ev_modem), .ev_tx_done(ev_tx_done),
    .ev_rx_timeout(ev_rx_timeout), .irq(irq0), .rx_dma_busy(busy0));

  uart_irq_ctrl #(.CHANNEL(2)) dut_c2 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata2), .rx_count(rx_count),
    .tx_count(tx_count), .rx_data_ready(rx_data_ready), .ev_error(ev_error),
    .ev_modem(ev_modem), .ev_tx_done(ev_tx_done),
    .ev_rx_timeout(ev_rx_timeout), .irq(irq2), .rx_dma_busy(busy2));

  int checks = 0;
  int errors = 0;
  string phase = "R10";
  bit done = 0;

  // ---------------- reference model ----------------
  int m_ctl, m_fset, m_mask;
  int m_src [2];

  function automatic int scale(int ch);
    if (ch == 0) return 32;
    if (ch == 1 || ch == 4) return 8;
    if (ch == 2 || ch == 3) return 2;
    return 0;
  endfunction

  function automatic int model_set(int ch);
    int s, txt, rxt;
    bit fen, txl, rxl;
    fen = m_fset[0];
    txt = ((m_fset >> 8) & 7) * scale(ch);
    rxt = (((m_fset >> 4) & 7) + 1) * scale(ch);
    txl = fen && (int'(tx_count) <= txt);
    if (fen) rxl = (int'(rx_count) >= rxt) || (rx_count != 0 && m_ctl[7] == 0);
    else     rxl = rx_data_ready;
    s = 0;
    if (rxl || ev_rx_timeout) s |= 1;
    if (ev_error)             s |= 2;
    if (txl || ev_tx_done)    s |= 4;
    if (ev_modem)             s |= 8;
    return s;
  endfunction

  function automatic int model_rd(int k);
    case (bus_addr)
      3'd0: return m_ctl;
      3'd1: return m_fset;
      3'd2: return m_mask;
      3'd3: return m_src[k];
      3'd4: return m_src[k] & ~m_mask & 15;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 0; m_fset = 0; m_mask = 0; m_src[0] = 0; m_src[1] = 0;
    end else begin
      int clr, s0, s2;
      clr = (bus_we && (bus_addr == 3 || bus_addr == 4)) ? (bus_wdata & 15) : 0;
      s0 = model_set(0);
      s2 = model_set(2);
      m_src[0] = ((m_src[0] & ~clr) | s0) & 15;
      m_src[1] = ((m_src[1] & ~clr) | s2) & 15;
      if (bus_we && bus_addr == 0) m_ctl  = bus_wdata & 16'hFF;
      if (bus_we && bus_addr == 1) m_fset = bus_wdata & 16'h7FF;
      if (bus_we && bus_addr == 2) m_mask = bus_wdata & 16'hF;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual 0x%0h expected 0x%0h", tag, $time, act, exp);
    end
  endtask

  // cycle compare against the model, mid-cycle
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk({phase, " irq ch0"}, int'(irq0), int'((m_src[0] & ~m_mask & 15) != 0));
      chk({phase, " irq ch2"}, int'(irq2), int'((m_src[1] & ~m_mask & 15) != 0));
      chk({phase, " busy ch0"}, int'(busy0), int'((m_ctl & 3) == 2 && rx_count == 0));
      chk({phase, " busy ch2"}, int'(busy2), int'((m_ctl & 3) == 2 && rx_count == 0));
      chk({phase, " rdata ch0"}, int'(rdata0), model_rd(0));
      chk({phase, " rdata ch2"}, int'(rdata2), model_rd(1));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    bus_we = 1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd_chk(string tag, int a, int e0, int e2);
    @(negedge clk);
    bus_addr = 3'(a);
    #2;
    chk(tag, int'(rdata0), e0);
    chk(tag, int'(rdata2), e2);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rx_count = 0; tx_count = 0; rx_data_ready = 0;
    ev_error = 0; ev_modem = 0; ev_tx_done = 0; ev_rx_timeout = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    phase = "R10";
    rd_chk("R10 ctrl after reset", 0, 0, 0);
    chk("R10 irq after reset", int'(irq0 | irq2), 0);
    rd_chk("R10 source after reset", 3, 0, 0);

    // R4 / R1 strobes set sticky bits at their positions
    phase = "R4";
    @(negedge clk); ev_error = 1;
    @(negedge clk); ev_error = 0;
    rd_chk("R1 error at bit 1", 3, 2, 2);
    @(negedge clk); ev_modem = 1;
    @(negedge clk); ev_modem = 0;
    rd_chk("R4 modem at bit 3", 3, 10, 10);
    chk("R2 irq with unmasked source", int'(irq0), 1);

    // R2 masking
    phase = "R2";
    wr(2, 15);
    rd_chk("R2 pending fully masked", 4, 0, 0);
    chk("R2 irq low fully masked", int'(irq0), 0);
    wr(2, 8);
    rd_chk("R2 pending partial mask", 4, 2, 2);
    chk("R2 irq high partial mask", int'(irq2), 1);

    // R3 clearing paths
    phase = "R3";
    wr(4, 2);
    rd_chk("R3 pending write clears source", 3, 8, 8);
    wr(3, 8);
    rd_chk("R3 source write clears", 3, 0, 0);
    wr(2, 0);

    // R5 / R7 transmit threshold: field 1 -> 32 vs 2
    phase = "R5";
    tx_count = 10;
    wr(1, 16'h101);
    rd_chk("R7 tx threshold scales by channel", 3, 4, 0);

    // R6 receive threshold: field 0 biased -> 32 vs 2
    phase = "R6";
    wr(0, 16'h80);
    rx_count = 3;
    wr(3, 15);
    rd_chk("R6 rx threshold with timeout enabled", 3, 4, 1);
    wr(0, 0);
    rx_count = 1;
    wr(3, 15);
    rd_chk("R6 non-empty with timeout disabled", 3, 5, 1);

    // R8 FIFO disabled
    phase = "R8";
    rx_count = 0; tx_count = 0; rx_data_ready = 1;
    wr(1, 0);
    wr(3, 15);
    rd_chk("R8 data ready sets rx, tx ignored", 3, 1, 1);
    rx_data_ready = 0; tx_count = 200;
    wr(3, 15);
    rd_chk("R8 no sources when idle", 3, 0, 0);

    // R9 DMA busy
    phase = "R9";
    wr(0, 2);
    @(negedge clk); #2;
    chk("R9 busy in DMA mode when empty", int'(busy0 & busy2), 1);
    @(negedge clk); rx_count = 1; #2;
    chk("R9 not busy when data present", int'(busy0 | busy2), 0);
    @(negedge clk); rx_count = 0;
    wr(0, 3);
    @(negedge clk); #2;
    chk("R9 not busy outside DMA mode", int'(busy0 | busy2), 0);

    // R4 transmit hand-off and timeout strobes
    phase = "R4";
    @(negedge clk); ev_tx_done = 1;
    @(negedge clk); ev_tx_done = 0;
    rd_chk("R4 tx hand-off sets bit 2", 3, 4, 4);
    wr(3, 15);
    @(negedge clk); ev_rx_timeout = 1;
    @(negedge clk); ev_rx_timeout = 0;
    rd_chk("R4 timeout sets bit 0", 3, 1, 1);
    wr(3, 15);

    // R3 set wins over clear
    phase = "R3";
    @(negedge clk);
    ev_error = 1; bus_we = 1; bus_addr = 3; bus_wdata = 2;
    @(negedge clk);
    ev_error = 0; bus_we = 0;
    rd_chk("R3 set wins over clear", 3, 2, 2);

    // random traffic against the model
    phase = "R2";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      bus_we        = ($urandom_range(0, 3) == 0);
      bus_addr      = 3'($urandom_range(0, 7));
      bus_wdata     = 16'($urandom);
      rx_count      = 8'($urandom_range(0, 40));
      tx_count      = 8'($urandom_range(0, 40));
      rx_data_ready = 1'($urandom);
      ev_error      = ($urandom_range(0, 7) == 0);
      ev_modem      = ($urandom_range(0, 7) == 0);
      ev_tx_done    = ($urandom_range(0, 7) == 0);
      ev_rx_timeout = ($urandom_range(0, 7) == 0);
    end
    @(negedge clk);
    bus_we = 0;
    @(negedge clk);
    #3;
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule